// File: doc/BRIEF.md
# Burst-of-Two Separate-Port Synchronous SRAM Core

This block is a synthesizable memory core with the command and data behaviour of a quad-data-rate SRAM that has separate read and write ports and a burst length of two. It runs on a system clock at twice the K rate. The input `k_rise` is high in the system-clock cycles whose closing edge stands for a K rising edge, and low in those that stand for a K falling edge. The clock source drives it so that it alternates every cycle. Each read or write moves two data words on consecutive half-cycles. The external address selects a pair of array words: beat 0 goes to the even word and beat 1 goes to the odd word.

The read port and the write port are independent. A new read and a new write can each be accepted on every K rising edge, with no idle cycles. Read data comes back two K cycles after the command. A drive-enable flag, `q_oe`, takes the place of a tri-state output. Each write beat carries its own active-low enables, one per 9-bit byte lane, so any set of bytes in either beat can be left untouched.

Top module: `qdrb2_sram`

## Requirements
- R1: A read is accepted at a rising-slot edge (`k_rise`=1) where `rd_n` is low, using `addr` at that edge. Beat 0 appears on `q` with `q_oe` high after the fourth following clock edge, which is the K rising edge two K cycles later. Beat 1 replaces it one clock edge after that.
- R2: When `rd_n` is high at a rising-slot edge, the read port is deselected. For both beat slots that would follow, `q_oe` is low and `q` is all zeros.
- R3: A write is accepted at a rising-slot edge where `wr_n` is low. Beat 0 data and enables are taken at that edge. The write address and the beat 1 data and enables are taken at the next edge, which is a falling-slot edge.
- R4: When `wr_n` is high at a rising-slot edge, the address, data and enables of that K cycle are ignored, and the array keeps its contents.
- R5: Byte lane i is data bits [9i+8:9i], and `bw_n[i]` enables it, active low. A 0 writes that byte of that beat. A 1 keeps the stored byte. The two beats are masked independently.
- R6: Beat 0 of a burst maps to array word 2·addr and beat 1 maps to word 2·addr+1. A read returns word 2·addr first, then word 2·addr+1.
- R7: A read and a write to the same pair in the same K cycle: the read returns the newly written bytes merged with the unwritten old ones. A write accepted in a later K cycle is not visible to that read.
- R8: Reads and writes can each be accepted on every consecutive K rising edge, and every read returns correct data without gaps.
- R9: Synchronous reset empties both latency pipelines and sets `q_oe` low and `q` to zero. It does not change the array contents.
- R10: `q_oe` changes only at rising-slot edges. It keeps its value across the falling-slot edge that presents beat 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at twice the K rate |
| rst | input | 1 | Synchronous reset, active high |
| k_rise | input | 1 | 1 in the cycle ending at a K rising edge, 0 in the cycle ending at a K falling edge |
| rd_n | input | 1 | Read select, active low, sampled at rising-slot edges |
| wr_n | input | 1 | Write select, active low, sampled at rising-slot edges |
| addr | input | ADDR_W | Word-pair address: read address at rising slots, write address at falling slots |
| d | input | DATA_W | Write data, beat 0 at the rising slot and beat 1 at the falling slot |
| bw_n | input | LANES | Per-lane write enables for the current beat, active low |
| q | output | DATA_W | Read data, beat 0 then beat 1 |
| q_oe | output | 1 | High while `q` carries read data |

## Verification
A scoreboard checks every K cycle's read slot. The input patterns are full-width fills and readbacks, each of which would expose a swapped beat order or a wrong pair mapping. Masked writes use complementary, partial and all-aborted enables, and these separate per-beat masking from per-burst masking. Bursts in which the read address differs from the write address show whether the write address is taken in the falling slot. Back-to-back same-pair traffic shows where a read's snapshot point lies relative to the writes around it. Write deselects that carry live data, read deselects between reads, and a reset in the middle of traffic that is then followed by readback check the ignore, idle and retention cases.

// File: rtl/qdrb2_pkg.sv
package qdrb2_pkg;
   localparam int LANE_W = 9;
   typedef enum logic {
      SLOT_FALL = 1'b0,
      SLOT_RISE = 1'b1
   } slot_e;
endpackage

// File: rtl/qdrb2_wr_capture.sv
module qdrb2_wr_capture
   import qdrb2_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int LANES  = 4,
   parameter int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              k_rise,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] d,
   input  logic [LANES-1:0]  bw_n,
   output logic              we,
   output logic [ADDR_W-1:0] wa,
   output logic [DATA_W-1:0] wd0,
   output logic [DATA_W-1:0] wd1,
   output logic [LANES-1:0]  wm0,
   output logic [LANES-1:0]  wm1
);
   slot_e            slot;
   logic             armed;
   logic [DATA_W-1:0] beat0_d;
   logic [LANES-1:0]  beat0_m;

   assign slot = slot_e'(k_rise);

   // Beat 0 and the select are taken at the rising slot.
   always_ff @(posedge clk) begin
      if (rst) begin
         armed   <= 1'b0;
         beat0_d <= '0;
         beat0_m <= '1;
      end else if (slot == SLOT_RISE) begin
         armed   <= ~wr_n;
         beat0_d <= d;
         beat0_m <= bw_n;
      end
   end

   // Address and beat 1 are taken live in the falling slot.
   assign we  = armed && (slot == SLOT_FALL);
   assign wa  = addr;
   assign wd0 = beat0_d;
   assign wm0 = beat0_m;
   assign wd1 = d;
   assign wm1 = bw_n;

   a_r3_commit_follows_select: assert property (@(posedge clk) disable iff (rst)
      we |-> ($past(k_rise) && !$past(wr_n)));
   a_r4_deselect_no_commit: assert property (@(posedge clk) disable iff (rst)
      (k_rise && wr_n) |=> !we);
endmodule

// File: rtl/qdrb2_array.sv
module qdrb2_array
   import qdrb2_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int LANES  = 4,
   parameter int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] wa,
   input  logic [DATA_W-1:0] wd0,
   input  logic [DATA_W-1:0] wd1,
   input  logic [LANES-1:0]  wm0,
   input  logic [LANES-1:0]  wm1,
   input  logic [ADDR_W-1:0] ra,
   output logic [DATA_W-1:0] rw0,
   output logic [DATA_W-1:0] rw1
);
   localparam int WORDS = 2 ** (ADDR_W + 1);

   logic [DATA_W-1:0] mem [WORDS];
   logic [DATA_W-1:0] old0, old1, new0, new1;

   assign old0 = mem[{wa, 1'b0}];
   assign old1 = mem[{wa, 1'b1}];

   // Per-lane merge: an enabled lane takes new data, others keep old bytes.
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign new0[l*LANE_W +: LANE_W] = wm0[l] ? old0[l*LANE_W +: LANE_W]
                                               : wd0[l*LANE_W +: LANE_W];
      assign new1[l*LANE_W +: LANE_W] = wm1[l] ? old1[l*LANE_W +: LANE_W]
                                               : wd1[l*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk) begin
      if (we) begin
         mem[{wa, 1'b0}] <= new0;
         mem[{wa, 1'b1}] <= new1;
      end
   end

   assign rw0 = mem[{ra, 1'b0}];
   assign rw1 = mem[{ra, 1'b1}];
endmodule

// File: rtl/qdrb2_rd_pipe.sv
module qdrb2_rd_pipe
   import qdrb2_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int LANES     = 4,
   parameter int DATA_W    = LANES * LANE_W,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              k_rise,
   input  logic              rd_n,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] ra,
   input  logic [DATA_W-1:0] rw0,
   input  logic [DATA_W-1:0] rw1,
   output logic [DATA_W-1:0] q,
   output logic              q_oe
);
   slot_e             slot;
   logic              cmd_v, snap_v;
   logic [ADDR_W-1:0] cmd_a;
   logic [DATA_W-1:0] snap0, snap1, hold1;
   logic [DATA_W-1:0] out0, out1;

   assign slot = slot_e'(k_rise);
   assign ra   = cmd_a;

   // ZERO_IDLE picks whether an undriven bus reads as zeros or holds stale data.
   if (ZERO_IDLE) begin : g_zero
      assign out0 = snap_v ? snap0 : '0;
      assign out1 = snap_v ? snap1 : '0;
   end else begin : g_hold
      assign out0 = snap0;
      assign out1 = snap1;
   end

   // Stage 1: command at K edge n. Stage 2: array snapshot at n+1.
   // Output: beat 0 at n+2, beat 1 in the falling slot after it.
   always_ff @(posedge clk) begin
      if (rst) begin
         cmd_v  <= 1'b0;
         cmd_a  <= '0;
         snap_v <= 1'b0;
         snap0  <= '0;
         snap1  <= '0;
         hold1  <= '0;
         q      <= '0;
         q_oe   <= 1'b0;
      end else if (slot == SLOT_RISE) begin
         cmd_v  <= ~rd_n;
         cmd_a  <= addr;
         snap_v <= cmd_v;
         snap0  <= rw0;
         snap1  <= rw1;
         q_oe   <= snap_v;
         q      <= out0;
         hold1  <= out1;
      end else begin
         q      <= hold1;
      end
   end

   a_r1_beat0_latency: assert property (@(posedge clk) disable iff (rst)
      (k_rise && !rd_n) |=> ##4 q_oe);
   a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
      (k_rise && rd_n) |=> ##4 !q_oe);
   a_r10_oe_held_in_fall: assert property (@(posedge clk)
      (!k_rise && !rst) |=> $stable(q_oe));
   if (ZERO_IDLE) begin : g_idle_chk
      a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
         !q_oe |-> (q == '0));
   end
endmodule

// File: rtl/qdrb2_sram.sv
module qdrb2_sram
   import qdrb2_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int LANES     = 4,
   parameter int DATA_W    = LANES * LANE_W,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              k_rise,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] d,
   input  logic [LANES-1:0]  bw_n,
   output logic [DATA_W-1:0] q,
   output logic              q_oe
);
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("qdrb2_sram: ADDR_W out of range");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("qdrb2_sram: LANES must be at least 1");
   end
   if (DATA_W != LANES * LANE_W) begin : g_bad_width
      $error("qdrb2_sram: DATA_W must equal LANES * 9");
   end

   logic              we;
   logic [ADDR_W-1:0] wa, ra;
   logic [DATA_W-1:0] wd0, wd1, rw0, rw1;
   logic [LANES-1:0]  wm0, wm1;

   qdrb2_wr_capture #(.ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(DATA_W)) u_wr (
      .clk(clk), .rst(rst), .k_rise(k_rise), .wr_n(wr_n), .addr(addr),
      .d(d), .bw_n(bw_n), .we(we), .wa(wa), .wd0(wd0), .wd1(wd1),
      .wm0(wm0), .wm1(wm1)
   );

   qdrb2_array #(.ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(DATA_W)) u_mem (
      .clk(clk), .we(we), .wa(wa), .wd0(wd0), .wd1(wd1), .wm0(wm0),
      .wm1(wm1), .ra(ra), .rw0(rw0), .rw1(rw1)
   );

   qdrb2_rd_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(DATA_W),
                   .ZERO_IDLE(ZERO_IDLE)) u_rd (
      .clk(clk), .rst(rst), .k_rise(k_rise), .rd_n(rd_n), .addr(addr),
      .ra(ra), .rw0(rw0), .rw1(rw1), .q(q), .q_oe(q_oe)
   );

   a_r9_reset_clears: assert property (@(posedge clk) rst |=> (!q_oe && q == '0));
endmodule

// File: tb/qdrb2_sram_test.sv
module qdrb2_sram_test;
   localparam int AW = 5;
   localparam int LN = 4;
   localparam int DW = LN * 9;
   localparam int PAIRS = 2 ** AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          k_rise = 1'b0;
   logic          rd_n = 1'b1;
   logic          wr_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] d = '0;
   logic [LN-1:0] bw_n = '1;
   logic [DW-1:0] q;
   logic          q_oe;

   int checks = 0;
   int fails  = 0;
   int unsigned edge_no = 0;

   typedef struct {
      int unsigned tag;
      logic        oe;
      logic [DW-1:0] q0;
      logic [DW-1:0] q1;
      string       req;
   } exp_t;
   exp_t exp_q[$];
   logic seen_oe;

   logic [DW-1:0] ref_mem [2*PAIRS];

   qdrb2_sram #(.ADDR_W(AW), .LANES(LN)) uut (
      .clk(clk), .rst(rst), .k_rise(k_rise), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .d(d), .bw_n(bw_n), .q(q), .q_oe(q_oe)
   );

   always #4 clk = ~clk;
   always @(posedge clk) edge_no <= edge_no + 1;

   task automatic check(input string req, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int p, input int b, input int s);
      return DW'(p * 36'h1F3 + b * 36'h9A50 + s * 36'h31337 + 36'h5A5A5);
   endfunction

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                           input logic [DW-1:0] nw,
                                           input logic [LN-1:0] m);
      logic [DW-1:0] r = old;
      for (int l = 0; l < LN; l++)
         if (!m[l]) r[l*9 +: 9] = nw[l*9 +: 9];
      return r;
   endfunction

   // One K cycle: rising slot then falling slot.
   task automatic kcycle(input logic rdn, input int ra, input logic wrn,
                         input int wa, input logic [DW-1:0] d0,
                         input logic [DW-1:0] d1, input logic [LN-1:0] m0,
                         input logic [LN-1:0] m1, input string req);
      exp_t e;
      @(negedge clk);
      k_rise = 1'b1; rd_n = rdn; wr_n = wrn; addr = AW'(ra); d = d0; bw_n = m0;
      if (!rst) begin
         if (!wrn) begin
            ref_mem[2*wa]   = merge(ref_mem[2*wa], d0, m0);
            ref_mem[2*wa+1] = merge(ref_mem[2*wa+1], d1, m1);
         end
         e.tag = edge_no + 1;
         e.oe  = !rdn;
         e.q0  = rdn ? '0 : ref_mem[2*ra];
         e.q1  = rdn ? '0 : ref_mem[2*ra+1];
         e.req = req;
         exp_q.push_back(e);
      end
      @(negedge clk);
      k_rise = 1'b0; rd_n = 1'b1; wr_n = 1'b1; addr = AW'(wa); d = d1; bw_n = m1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) kcycle(1'b1, 0, 1'b1, 0, '0, '0, '1, '1, "R2");
   endtask

   // Scoreboard monitor.
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         if (edge_no == exp_q[0].tag + 4) begin
            check(exp_q[0].req, DW'(q_oe), DW'(exp_q[0].oe), "oe beat0");
            check(exp_q[0].req, q, exp_q[0].q0, "q beat0");
            seen_oe = q_oe;
         end else if (edge_no == exp_q[0].tag + 5) begin
            check(exp_q[0].req, q, exp_q[0].q1, "q beat1");
            check("R10", DW'(q_oe), DW'(seen_oe), "oe held over fall");
            void'(exp_q.pop_front());
         end
      end
   end

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 2 * PAIRS; i++) ref_mem[i] = '0;
      idle(3);
      check("R9", DW'(q_oe), '0, "oe in reset");
      check("R9", q, '0, "q in reset");
      @(negedge clk); rst = 1'b0; k_rise = 1'b0;
      // R8: fill every pair while reading the previous one, no gaps
      for (int p = 0; p < PAIRS; p++)
         kcycle((p == 0), (p == 0) ? 0 : p - 1, 1'b0, p,
                pat(p, 0, 1), pat(p, 1, 1), '0, '0, "R8");
      // R1 / R6: readback of all pairs, beat order even then odd
      for (int p = 0; p < PAIRS; p++)
         kcycle(1'b0, p, 1'b1, 0, '0, '0, '1, '1, (p % 2) ? "R6" : "R1");
      // R5: independent masks per beat
      kcycle(1'b1, 0, 1'b0, 3, pat(3, 0, 7), pat(3, 1, 7), 4'b0101, 4'b1010, "R2");
      kcycle(1'b0, 3, 1'b1, 0, '0, '0, '1, '1, "R5");
      kcycle(1'b1, 0, 1'b0, 7, pat(7, 0, 8), pat(7, 1, 8), 4'b0000, 4'b1111, "R2");
      kcycle(1'b0, 7, 1'b0, 8, pat(8, 0, 9), pat(8, 1, 9), 4'b1111, 4'b1111, "R5");
      kcycle(1'b0, 8, 1'b1, 0, '0, '0, '1, '1, "R5");
      // R4: write deselect with live data and enables
      kcycle(1'b1, 0, 1'b1, 4, pat(4, 0, 3), pat(4, 1, 3), '0, '0, "R2");
      kcycle(1'b0, 4, 1'b1, 4, pat(4, 0, 4), pat(4, 1, 4), '0, '0, "R4");
      // R3: read address differs from write address in the same burst
      kcycle(1'b0, 9, 1'b0, 10, pat(10, 0, 5), pat(10, 1, 5), '0, '0, "R3");
      kcycle(1'b0, 10, 1'b1, 0, '0, '0, '1, '1, "R3");
      // R7: same-pair read and write, then a later write is not seen early
      kcycle(1'b0, 6, 1'b0, 6, pat(6, 0, 6), pat(6, 1, 6), 4'b0011, 4'b1100, "R7");
      kcycle(1'b0, 6, 1'b0, 6, pat(6, 0, 2), pat(6, 1, 2), '0, '0, "R7");
      kcycle(1'b0, 6, 1'b1, 0, '0, '0, '1, '1, "R7");
      // R2: deselects interleaved with reads
      for (int i = 0; i < 6; i++)
         kcycle(i[0], i + 11, 1'b1, 0, '0, '0, '1, '1, i[0] ? "R2" : "R1");
      // R9: reset in the middle of pending reads, array kept
      kcycle(1'b0, 12, 1'b1, 0, '0, '0, '1, '1, "R9");
      kcycle(1'b0, 13, 1'b1, 0, '0, '0, '1, '1, "R9");
      @(negedge clk); rst = 1'b1; exp_q.delete();
      k_rise = 1'b0;
      idle(2);
      check("R9", DW'(q_oe), '0, "oe after mid reset");
      check("R9", q, '0, "q after mid reset");
      @(negedge clk); rst = 1'b0; k_rise = 1'b0;
      idle(3);
      check("R9", DW'(q_oe), '0, "oe idle after reset");
      kcycle(1'b0, 12, 1'b1, 0, '0, '0, '1, '1, "R9");
      kcycle(1'b0, 3, 1'b1, 0, '0, '0, '1, '1, "R9");
      idle(4);
      finish_run();
   end
endmodule